// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps wall-clock time and calendar date as packed BCD fields: seconds, minutes, hours, day of week, day of month, month, two-digit year and century. It advances by one second on each single-cycle pulse of `tick_1hz`. Month lengths come from the calendar, and February gains a 29th day in leap years.

The host sees the time through a byte-wide register window that behaves like plain SRAM: a combinational read port and a one-cycle write strobe. The host never reads the counters directly. It reads a mirror of them, which the counting logic refreshes one cycle after each tick.

A control byte sets how the mirror and the counters interact. One bit freezes the mirror so that a multi-byte read stays coherent. Another bit opens a write session: host writes collect in the mirror, and they load into the counters at once when that bit is cleared. The low six bits hold a calibration code. The block stores that code and does not use it.

Top module: `rtc_regfile`

## Requirements
- R1: After reset, with no tick, the reads are: seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, date 0x01, month 0x01, year 0x00, century equal to parameter CENT_RST (default 0x20), and control 0x00.
- R2: The offsets within the 16-byte window are: century 0x1, control 0x8, seconds 0x9, minutes 0xA, hours 0xB, day of week 0xC, date 0xD, month 0xE, year 0xF. Every other offset reads 0x00, and a write to it changes no readable byte.
- R3: Each tick advances seconds by one in BCD. Seconds 0x59 wraps to 0x00 and carries into minutes. Minutes 0x59 wraps to 0x00 and carries into hours. Hours 0x23 wraps to 0x00 and carries one day.
- R4: The day of week advances on every day carry and wraps from 0x07 to 0x01.
- R5: A day carry past the last date of the month sets the date to 0x01 and advances the month. The last date is 0x30 for months 0x04, 0x06, 0x09 and 0x11, and 0x31 for the other months apart from February.
- R6: February (0x02) ends on 0x29 when the BCD year is a multiple of four (year 0x00 included), and on 0x28 otherwise.
- R7: Month 0x12 wraps to 0x01 and carries into the year. Year 0x99 wraps to 0x00 and carries into the century. Century 0x99 wraps to 0x00.
- R8: With control bits 7 and 6 clear, a tick sampled at clock edge k changes the counters at edge k. The mirror takes the new counter values at edge k+1. With no tick and no load, the counters hold.
- R9: While control bit 6 is set, the mirror is not refreshed and the counters keep counting. After bit 6 is cleared, the first refresh shows the full elapsed time.
- R10: While control bit 7 is set, the mirror is not refreshed and holds the bytes the host writes. A write of the control byte that changes bit 7 from 1 to 0 copies every mirror time byte into the counters on that edge. A tick in the same cycle is dropped.
- R11: A write to the control byte stores all 8 bits and reads back unchanged. Bits 5:0 have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| tick_1hz | input | 1 | One-cycle pulse that advances time by one second |
| wr_en | input | 1 | Host write strobe for one cycle |
| addr | input | ADDR_W | Host byte address; the clock bytes sit in the top 16 locations |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Combinational read data for `addr` |

## Verification
On every cycle the assertions check five things:
- the seconds wrap;
- that the counters hold when there is no tick and no load;
- that a refresh copies the counters exactly;
- that the mirror stays frozen while bit 6 is set;
- that the counters take the mirror on a load and that the control byte stores what was written.

Month lengths, the leap-year rule, the year and century carries, the day-of-week wrap and the dropping of a coincident tick can be seen only in the bench's scenarios. Those scenarios preset a calendar point, tick once and read every byte back through the bus.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_FIELDS = 8;
  localparam int CTRL_W_BIT = 7;
  localparam int CTRL_R_BIT = 6;
  localparam logic [3:0] OFF_CTRL = 4'h8;

  typedef logic [7:0] bcd_t;
  typedef bcd_t [NUM_FIELDS-1:0] time_t;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_WDAY  = 3'd3,
    FLD_DATE  = 3'd4,
    FLD_MONTH = 3'd5,
    FLD_YEAR  = 3'd6,
    FLD_CENT  = 3'd7
  } field_e;

  typedef struct packed {
    logic   hit;
    field_e fld;
  } decode_t;

  function automatic bcd_t bcd_inc(bcd_t v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  // 10 = 2 (mod 4), so the value mod 4 is (2*tens + ones) mod 4.
  function automatic logic leap_year(bcd_t yr);
    logic [1:0] s;
    s = {yr[4], 1'b0} + yr[1:0];
    return (s == 2'b00);
  endfunction

  function automatic decode_t decode_offset(logic [3:0] off);
    decode_t d;
    d.hit = 1'b1;
    d.fld = FLD_SEC;
    case (off)
      4'h9:    d.fld = FLD_SEC;
      4'hA:    d.fld = FLD_MIN;
      4'hB:    d.fld = FLD_HOUR;
      4'hC:    d.fld = FLD_WDAY;
      4'hD:    d.fld = FLD_DATE;
      4'hE:    d.fld = FLD_MONTH;
      4'hF:    d.fld = FLD_YEAR;
      4'h1:    d.fld = FLD_CENT;
      default: d.hit = 1'b0;
    endcase
    return d;
  endfunction

  function automatic time_t reset_time(bcd_t cent);
    time_t t;
    t = '0;
    t[FLD_WDAY]  = 8'h01;
    t[FLD_DATE]  = 8'h01;
    t[FLD_MONTH] = 8'h01;
    t[FLD_CENT]  = cent;
    return t;
  endfunction
endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_pkg::*;
(
  input  bcd_t month,
  input  bcd_t year,
  output bcd_t last_date
);
  always_comb begin
    case (month)
      8'h02:                      last_date = leap_year(year) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
      default:                    last_date = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_pkg::*;
#(
  parameter bcd_t CENT_RST = 8'h20
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  load,
  input  time_t load_val,
  output time_t cnt
);
  localparam time_t RST_VAL = reset_time(CENT_RST);
  localparam time_t FMIN = {8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  time_t cnt_q, cnt_d, fmax;
  bcd_t  last_date;
  logic [NUM_FIELDS-1:0] wrap, adv;

  rtc_month_len u_len (
    .month     (cnt_q[FLD_MONTH]),
    .year      (cnt_q[FLD_YEAR]),
    .last_date (last_date)
  );

  assign fmax = {8'h99, 8'h99, 8'h12, last_date, 8'h07, 8'h23, 8'h59, 8'h59};

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_wrap
    assign wrap[i] = (cnt_q[i] == fmax[i]);
  end

  // Carry chain: day of week and date both advance on the day carry.
  always_comb begin
    adv[FLD_SEC]   = tick;
    adv[FLD_MIN]   = adv[FLD_SEC]   & wrap[FLD_SEC];
    adv[FLD_HOUR]  = adv[FLD_MIN]   & wrap[FLD_MIN];
    adv[FLD_WDAY]  = adv[FLD_HOUR]  & wrap[FLD_HOUR];
    adv[FLD_DATE]  = adv[FLD_HOUR]  & wrap[FLD_HOUR];
    adv[FLD_MONTH] = adv[FLD_DATE]  & wrap[FLD_DATE];
    adv[FLD_YEAR]  = adv[FLD_MONTH] & wrap[FLD_MONTH];
    adv[FLD_CENT]  = adv[FLD_YEAR]  & wrap[FLD_YEAR];
  end

  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (load)        cnt_d[i] = load_val[i];
      else if (adv[i]) cnt_d[i] = wrap[i] ? FMIN[i] : bcd_inc(cnt_q[i]);
      else             cnt_d[i] = cnt_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= RST_VAL;
    else if (load || tick) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/rtc_host_port.sv
module rtc_host_port
  import rtc_pkg::*;
#(
  parameter int   ADDR_W   = 4,
  parameter bcd_t CENT_RST = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  bcd_t              wdata,
  input  time_t             cnt,
  output bcd_t              rdata,
  output time_t             mirror,
  output bcd_t              ctrl,
  output logic              load
);
  localparam time_t RST_VAL = reset_time(CENT_RST);

  logic    in_win, wr_ctrl, wr_time, refresh, tick_q, mir_en;
  decode_t dec;
  time_t   mir_q, mir_d;
  bcd_t    ctrl_q;

  if (ADDR_W > 4) begin : g_wide
    assign in_win = &addr[ADDR_W-1:4];
  end else begin : g_exact
    assign in_win = 1'b1;
  end

  assign dec     = decode_offset(addr[3:0]);
  assign wr_ctrl = wr_en & in_win & (addr[3:0] == OFF_CTRL);
  assign wr_time = wr_en & in_win & dec.hit;
  assign load    = wr_ctrl & ctrl_q[CTRL_W_BIT] & ~wdata[CTRL_W_BIT];
  assign refresh = tick_q & ~ctrl_q[CTRL_R_BIT] & ~ctrl_q[CTRL_W_BIT] & ~load;
  assign mir_en  = refresh | wr_time;

  always_comb begin
    mir_d = mir_q;
    if (refresh) mir_d = cnt;
    if (wr_time) mir_d[dec.fld] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mir_q <= RST_VAL;
    else if (mir_en) mir_q <= mir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (in_win) begin
      if (addr[3:0] == OFF_CTRL) rdata = ctrl_q;
      else if (dec.hit)          rdata = mir_q[dec.fld];
    end
  end

  assign mirror = mir_q;
  assign ctrl   = ctrl_q;
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int   ADDR_W   = 4,
  parameter bcd_t CENT_RST = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  logic [1:0] rst_sync;
  logic       rst_core_n;
  time_t      cnt_flat, mir_flat;
  bcd_t       ctrl_q;
  logic       load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  rtc_time_counter #(.CENT_RST(CENT_RST)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .tick     (tick_1hz),
    .load     (load),
    .load_val (mir_flat),
    .cnt      (cnt_flat)
  );

  rtc_host_port #(.ADDR_W(ADDR_W), .CENT_RST(CENT_RST)) u_port (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .tick   (tick_1hz),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .cnt    (cnt_flat),
    .rdata  (rdata),
    .mirror (mir_flat),
    .ctrl   (ctrl_q),
    .load   (load)
  );
endmodule

// File: rtl/rtc_regfile_checker.sv
module rtc_regfile_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_1hz,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [63:0]       cnt_flat,
  input logic [63:0]       mir_flat,
  input logic [7:0]        ctrl_q
);
  logic win, ld, wr_time, wr_ctl, tick_d;

  if (ADDR_W > 4) begin : g_wide
    assign win = &addr[ADDR_W-1:4];
  end else begin : g_exact
    assign win = 1'b1;
  end

  assign wr_ctl  = wr_en & win & (addr[3:0] == 4'h8);
  assign wr_time = wr_en & win & ((addr[3:0] == 4'h1) | (addr[3:0] >= 4'h9));
  assign ld      = wr_ctl & ctrl_q[7] & ~wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_d <= 1'b0;
    else        tick_d <= tick_1hz;
  end

  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !ld && cnt_flat[7:0] == 8'h59) |=> (cnt_flat[7:0] == 8'h00))
    else $error("seconds did not wrap");

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1hz && !ld) |=> $stable(cnt_flat))
    else $error("counters moved without tick or load");

  assert_refresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_d && ctrl_q[7:6] == 2'b00 && !wr_en) |=> (mir_flat == $past(cnt_flat)))
    else $error("mirror refresh mismatch");

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[6] && !wr_time) |=> $stable(mir_flat))
    else $error("mirror changed while frozen");

  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt_flat == $past(mir_flat)))
    else $error("load did not copy mirror");

  assert_ctrl_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (ctrl_q == $past(wdata)))
    else $error("control byte not stored");
endmodule

bind rtc_regfile rtc_regfile_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .tick_1hz (tick_1hz),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .cnt_flat (cnt_flat),
  .mir_flat (mir_flat),
  .ctrl_q   (ctrl_q)
);

// File: tb/tb_rtc_regfile.sv
`timescale 1ns/1ps
module tb_rtc_regfile;
  localparam int AW = 4;
  localparam int NV = 17;

  logic clk = 1'b0;
  logic rst_n, tick_1hz, wr_en;
  logic [AW-1:0] addr;
  logic [7:0] wdata, rdata;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  rtc_regfile #(.ADDR_W(AW), .CENT_RST(8'h20)) dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  // Field order of a 64-bit time word, low byte first: sec, min, hour, wday, date, month, year, century
  localparam logic [3:0] FOFF [8] = '{4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF, 4'h1};

  // {preset, expected after one tick}; each word is cent_year_month_date_wday_hour_min_sec
  localparam logic [127:0] VECS [NV] = '{
    {64'h20_24_03_15_03_10_20_30, 64'h20_24_03_15_03_10_20_31}, // R8 plain second
    {64'h20_24_03_15_03_10_20_59, 64'h20_24_03_15_03_10_21_00}, // R3 minute carry
    {64'h20_24_03_15_03_23_59_59, 64'h20_24_03_16_04_00_00_00}, // R3 day carry
    {64'h20_24_03_17_07_23_59_59, 64'h20_24_03_18_01_00_00_00}, // R4 weekday wrap
    {64'h20_24_01_31_02_23_59_59, 64'h20_24_02_01_03_00_00_00}, // R5 31-day month
    {64'h20_24_04_30_05_23_59_59, 64'h20_24_05_01_06_00_00_00}, // R5 30-day month
    {64'h20_24_11_30_06_23_59_59, 64'h20_24_12_01_07_00_00_00}, // R5 30-day month
    {64'h20_24_03_30_01_23_59_59, 64'h20_24_03_31_02_00_00_00}, // R5 no wrap at 30
    {64'h20_23_02_28_02_23_59_59, 64'h20_23_03_01_03_00_00_00}, // R6 common year
    {64'h20_24_02_28_03_23_59_59, 64'h20_24_02_29_04_00_00_00}, // R6 leap 24
    {64'h20_24_02_29_04_23_59_59, 64'h20_24_03_01_05_00_00_00}, // R6 leap end
    {64'h20_00_02_28_01_23_59_59, 64'h20_00_02_29_02_00_00_00}, // R6 year 00
    {64'h20_16_02_28_01_23_59_59, 64'h20_16_02_29_02_00_00_00}, // R6 odd tens leap
    {64'h20_10_02_28_01_23_59_59, 64'h20_10_03_01_02_00_00_00}, // R6 odd tens common
    {64'h20_23_12_31_07_23_59_59, 64'h20_24_01_01_01_00_00_00}, // R7 new year
    {64'h20_99_12_31_05_23_59_59, 64'h21_00_01_01_06_00_00_00}, // R7 century carry
    {64'h99_99_12_31_05_23_59_59, 64'h00_00_01_01_06_00_00_00}  // R7 century wrap
  };
  localparam int VREQ [NV] = '{8, 3, 3, 4, 5, 5, 5, 5, 6, 6, 6, 6, 6, 6, 7, 7, 7};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic host_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic host_read(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic preset(input logic [63:0] t);
    host_write(4'h8, 8'h80);
    for (int f = 0; f < 8; f++) host_write(FOFF[f], t[f*8 +: 8]);
    host_write(4'h8, 8'h00);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; tick_1hz = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    for (int f = 0; f < 8; f++) begin
      host_read(FOFF[f], rd);
      check("R1", rd, (f == 3 || f == 4 || f == 5) ? 8'h01 : (f == 7) ? 8'h20 : 8'h00);
    end
    host_read(4'h8, rd); check("R1 ctrl", rd, 8'h00);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      preset(VECS[v][127:64]);
      tick();
      step();
      for (int f = 0; f < 8; f++) begin
        host_read(FOFF[f], rd);
        check($sformatf("R%0d vec%0d byte%0d", VREQ[v], v, f), rd, VECS[v][f*8 +: 8]);
      end
    end

    // R8 refresh latency
    preset(64'h20_24_06_10_01_12_00_10);
    tick();
    host_read(4'h9, rd); check("R8 before refresh", rd, 8'h10);
    step();
    host_read(4'h9, rd); check("R8 after refresh", rd, 8'h11);

    // R9 freeze
    host_write(4'h8, 8'h40);
    tick(); step(); tick(); step();
    host_read(4'h9, rd); check("R9 frozen sec", rd, 8'h11);
    host_read(4'h8, rd); check("R9 ctrl", rd, 8'h40);
    host_write(4'h8, 8'h00);
    host_read(4'h9, rd); check("R9 no refresh yet", rd, 8'h11);
    tick(); step();
    host_read(4'h9, rd); check("R9 elapsed time", rd, 8'h14);

    // R10 write session and load
    host_write(4'h8, 8'h80);
    tick(); step();
    host_read(4'h9, rd); check("R10 no refresh", rd, 8'h14);
    host_write(4'h9, 8'h40);
    host_read(4'h9, rd); check("R10 held write", rd, 8'h40);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'h8; wdata = 8'h00; tick_1hz = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_1hz = 1'b0;
    step(); step();
    host_read(4'h9, rd); check("R10 tick dropped on load", rd, 8'h40);
    host_read(4'hA, rd); check("R10 minutes kept", rd, 8'h00);
    tick(); step();
    host_read(4'h9, rd); check("R10 counters loaded", rd, 8'h41);

    // R11 calibration bits stored, counting unaffected
    host_write(4'h8, 8'h2A);
    host_read(4'h8, rd); check("R11 ctrl readback", rd, 8'h2A);
    tick(); step();
    host_read(4'h9, rd); check("R11 counting", rd, 8'h42);
    host_write(4'h8, 8'h00);

    // R2 unmapped offsets
    host_write(4'h4, 8'h77);
    host_read(4'h4, rd); check("R2 unmapped 4", rd, 8'h00);
    host_read(4'h0, rd); check("R2 unmapped 0", rd, 8'h00);
    host_read(4'h9, rd); check("R2 sec kept", rd, 8'h42);
    host_read(4'h8, rd); check("R2 ctrl kept", rd, 8'h00);
    host_read(4'h1, rd); check("R2 century", rd, 8'h20);

    finish_run();
  end
endmodule